// File: doc/BRIEF.md
# Cartridge Save-RAM Bank Mapper

This block decodes the cartridge part of a 16-bit CPU bus. It chooses, for each request, whether the ROM, a battery-backed save RAM, a small control-register page or nothing answers. The bottom 2 MB of the 4 MB cartridge space is always ROM. The 2–4 MB window shows either the ROM behind it or the save RAM, and one control bit picks which. Save-RAM writes are accepted only while a two-bit unlock field in control register 0 holds the value 01.

The save RAM may be a full 16-bit array, or an 8-bit part wired to the even byte lane only or to the odd byte lane only. A static lane-mode input and a static size mask describe the fitted RAM. The block steers byte enables, the RAM word address and the write data to a 16-bit external RAM. A half-width part occupies one lane of that RAM, and the lane that is not fitted reads back as all ones. The ROM and the RAM both respond combinationally. The block registers the merged read data, so a response arrives one clock after each request.

Top module: `cart_save_mapper`

## Requirements
- R1: Any request with address bits [23:21] equal to 000 reaches ROM only (ram_cs stays low). A ROM read drives rom_cs with rom_addr = address bits [21:1].
- R2: For addresses 0x200000–0x3FFFFF, bit 0 of control register 0 selects the target. A value of 1 maps the save RAM. A value of 0 reads the ROM word at that same address.
- R3: A save-RAM write, word or byte, is performed only while bits [1:0] of control register 0 equal 01. With any other value the write is dropped and the RAM keeps its contents.
- R4: Eight 8-bit control registers sit at 0xA13000–0xA130FF, indexed by address bits [3:1]. A word write stores data bits [7:0]. A byte write stores data bits [7:0] only at an odd address; at an even address it has no effect. Reads of the page return 0xFFFF.
- R5: After reset every control register is zero, so the window shows ROM and save-RAM writes are locked.
- R6: With lane code 00 (both lanes), the byte offset o addresses byte o of the RAM. A word read returns byte o in bits [15:8] and byte o+1 in bits [7:0].
- R7: With lane code 10 (even lane only), RAM byte o>>1 is read in the high lane of a word read, and the low lane reads 0xFF. A byte read at an odd address returns 0xFF, and a byte write at an odd address is ignored.
- R8: With lane code 11 (odd lane only), RAM byte o>>1 is read in the low lane of a word read, and the high lane reads 0xFF. Byte reads at even addresses return 0xFF, and byte writes at even addresses are ignored.
- R9: Lane code 01 describes no fitted RAM. Window reads return 0xFFFF, and writes reach nothing.
- R10: The offset o is the address ANDed with cfg_mask, so addresses that differ only above the mask reach the same RAM byte.
- R11: rsp_valid rises exactly one clock after each req_valid. A read's rsp_rdata is due in that same cycle. A byte read returns its byte in both halves. Writes, control-page reads and unmapped addresses return 0xFFFF.
- R12: RAM port mapping: ram_addr = o[RAM_AW-1:1]; ram_be[1] enables bits [15:8] (the even-address byte) and ram_be[0] enables bits [7:0]; ram_cs is high only when at least one lane is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_wdata | input | 16 | Write data (byte writes use bits [7:0]) |
| cfg_lane | input | 2 | Lane code: 00 both, 10 even, 11 odd, 01 none |
| cfg_mask | input | RAM_AW | Save-RAM size mask (end minus start) |
| rom_rdata | input | 16 | ROM read data, combinational |
| ram_rdata | input | 16 | RAM read data, combinational |
| rom_cs | output | 1 | ROM select for reads |
| rom_addr | output | 21 | ROM word address |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write strobe |
| ram_be | output | 2 | RAM byte-lane enables |
| ram_addr | output | RAM_AW-1 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 16 | Response read data |

## Verification
The selects, the RAM address, the byte enables and the write strobe follow the request within the same cycle. The bench samples them 1 ns after it drives a request. Read data and rsp_valid pass through one register and are due one clock after the request. The bench drives on the falling edge and samples on the next falling edge, so one rising edge lies between drive and sample. Control-register and RAM writes take effect at the rising edge that closes the request. The bench updates its reference model only after that edge, so any later read is checked against the new state.

// File: rtl/cart_map_pkg.sv
// Package: shared types and helpers for the cartridge save-RAM mapper.
// Assumes a 24-bit byte address bus and 16-bit data.
package cart_map_pkg;

    typedef enum logic [1:0] {
        LANE_BOTH = 2'b00,
        LANE_NONE = 2'b01,
        LANE_EVEN = 2'b10,
        LANE_ODD  = 2'b11
    } lane_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_ROM  = 2'b01,
        TGT_RAM  = 2'b10,
        TGT_CTRL = 2'b11
    } target_e;

    localparam logic [15:0] CTRL_PAGE = 16'hA130;
    localparam logic [15:0] ALL_ONES  = 16'hFFFF;

    // Place one byte on both halves of a data word.
    function automatic logic [15:0] dup_byte(input logic [7:0] b);
        return {b, b};
    endfunction

endpackage

// File: rtl/cms_region_decode.sv
// Module: picks the target of a request from the upper address bits.
// Assumes page = address bits [23:8]; map_ram comes from control reg 0 bit 0.
module cms_region_decode
    import cart_map_pkg::*;
(
    input  logic [15:0] page,
    input  logic        map_ram,
    output target_e     target
);

    logic in_cart;
    logic upper_half;

    assign in_cart    = (page[15:14] == 2'b00);
    assign upper_half = page[13];

    // Priority: cartridge space first, then the control page.
    always_comb begin
        if (in_cart) begin
            target = (upper_half && map_ram) ? TGT_RAM : TGT_ROM;
        end else if (page == CTRL_PAGE) begin
            target = TGT_CTRL;
        end else begin
            target = TGT_NONE;
        end
    end

endmodule

// File: rtl/cms_ctrl_regs.sv
// Module: bank of byte-wide control registers in the I/O page.
// Assumes wr_en already qualifies a write to the control page.
module cms_ctrl_regs #(
    parameter int NREG  = 8,
    parameter int REG_W = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             word,
    input  logic             lsb,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output logic             map_ram,
    output logic             wr_unlock
);

    logic wr_hit;

    // Byte writes only land at odd addresses; word writes always land.
    assign wr_hit = wr_en && (word || lsb);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [REG_W-1:0] q;
        // Hold one control register; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_hit && (idx == IDX_W'(g))) begin
                q <= wdata;
            end
        end
    end

    assign map_ram   = g_reg[0].q[0];
    assign wr_unlock = (g_reg[0].q[1:0] == 2'b01);

    AST_EVEN_BYTE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !word && !lsb) |=> $stable(g_reg[0].q)); // R4

endmodule

// File: rtl/cms_lane_steer.sv
// Module: maps a save-RAM access onto a 16-bit RAM with byte enables,
// for full-width, even-lane-only, odd-lane-only or absent RAM.
// Assumes byte write data arrives in bits [7:0]; RAM reads are combinational.
module cms_lane_steer
    import cart_map_pkg::*;
#(
    parameter int RAM_AW = 16,
    localparam int RAM_WAW = RAM_AW - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               write,
    input  logic               word,
    input  logic               unlock,
    input  lane_e              lane,
    input  logic [RAM_AW-1:0]  off_in,
    input  logic [RAM_AW-1:0]  mask,
    input  logic [15:0]        wdata,
    input  logic [15:0]        ram_rdata,
    output logic               ram_cs,
    output logic               ram_we,
    output logic [1:0]         ram_be,
    output logic [RAM_WAW-1:0] ram_addr,
    output logic [15:0]        ram_wdata,
    output logic [15:0]        rd_data
);

    logic [RAM_AW-1:0] off;
    logic [7:0]        hi_b;
    logic [7:0]        lo_b;
    logic [7:0]        pick;

    // Mask the offset and force word accesses onto an even byte.
    always_comb begin
        off = off_in & mask;
        if (word) begin
            off[0] = 1'b0;
        end
    end

    assign ram_addr = off[RAM_AW-1:1];

    // Choose the lanes that carry real RAM for this access.
    always_comb begin
        unique case (lane)
            LANE_BOTH: ram_be = word ? 2'b11 : (off[0] ? 2'b01 : 2'b10);
            LANE_EVEN: ram_be = (word || !off[0]) ? 2'b10 : 2'b00;
            LANE_ODD:  ram_be = (word ||  off[0]) ? 2'b01 : 2'b00;
            default:   ram_be = 2'b00;
        endcase
    end

    assign ram_cs    = sel && (ram_be != 2'b00);
    assign ram_we    = ram_cs && write && unlock;
    assign ram_wdata = word ? wdata : dup_byte(wdata[7:0]);

    // Merge read data; lanes without RAM read as all ones.
    always_comb begin
        hi_b = ram_be[1] ? ram_rdata[15:8] : 8'hFF;
        lo_b = ram_be[0] ? ram_rdata[7:0]  : 8'hFF;
        pick = ram_be[1] ? hi_b : lo_b;
        rd_data = word ? {hi_b, lo_b} : dup_byte(pick);
    end

    AST_HALF_LANE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs && (lane == LANE_EVEN || lane == LANE_ODD)) |-> ($countones(ram_be) == 1)); // R7
    AST_ODD_LANE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs && lane == LANE_ODD) |-> !ram_be[1]); // R8
    AST_NO_RAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lane == LANE_NONE) |-> !ram_cs); // R9

endmodule

// File: rtl/cart_save_mapper.sv
// Module: top of the cartridge save-RAM bank mapper. Decodes the request,
// updates the control bank, steers save-RAM lanes and registers the response.
// Assumes cfg_lane and cfg_mask are static while requests are in flight.
module cart_save_mapper
    import cart_map_pkg::*;
#(
    parameter int RAM_AW = 16,
    parameter int NREG   = 8,
    localparam int RAM_WAW = RAM_AW - 1,
    localparam int IDX_W   = $clog2(NREG),
    localparam int ROM_AW  = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [23:0]        req_addr,
    input  logic               req_write,
    input  logic               req_word,
    input  logic [15:0]        req_wdata,
    input  logic [1:0]         cfg_lane,
    input  logic [RAM_AW-1:0]  cfg_mask,
    input  logic [15:0]        rom_rdata,
    input  logic [15:0]        ram_rdata,
    output logic               rom_cs,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               ram_cs,
    output logic               ram_we,
    output logic [1:0]         ram_be,
    output logic [RAM_WAW-1:0] ram_addr,
    output logic [15:0]        ram_wdata,
    output logic               rsp_valid,
    output logic [15:0]        rsp_rdata
);

    target_e     target;
    logic        map_ram;
    logic        wr_unlock;
    logic        ctrl_wr;
    logic [15:0] ram_rd;
    logic [15:0] rom_rd;
    logic [15:0] next_rdata;

    cms_region_decode u_decode (
        .page    (req_addr[23:8]),
        .map_ram (map_ram),
        .target  (target)
    );

    assign ctrl_wr = req_valid && req_write && (target == TGT_CTRL);

    cms_ctrl_regs #(.NREG(NREG), .REG_W(8)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr),
        .word      (req_word),
        .lsb       (req_addr[0]),
        .idx       (req_addr[IDX_W:1]),
        .wdata     (req_wdata[7:0]),
        .map_ram   (map_ram),
        .wr_unlock (wr_unlock)
    );

    cms_lane_steer #(.RAM_AW(RAM_AW)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (req_valid && (target == TGT_RAM)),
        .write     (req_write),
        .word      (req_word),
        .unlock    (wr_unlock),
        .lane      (lane_e'(cfg_lane)),
        .off_in    (req_addr[RAM_AW-1:0]),
        .mask      (cfg_mask),
        .wdata     (req_wdata),
        .ram_rdata (ram_rdata),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .ram_be    (ram_be),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .rd_data   (ram_rd)
    );

    // ROM is read-only: select it for reads that decode to ROM.
    assign rom_cs   = req_valid && !req_write && (target == TGT_ROM);
    assign rom_addr = req_addr[ROM_AW:1];

    // Format ROM data for word or byte reads.
    always_comb begin
        if (req_word) begin
            rom_rd = rom_rdata;
        end else begin
            rom_rd = dup_byte(req_addr[0] ? rom_rdata[7:0] : rom_rdata[15:8]);
        end
    end

    // Select the data that the response register captures.
    always_comb begin
        next_rdata = ALL_ONES;
        if (req_valid && !req_write) begin
            unique case (target)
                TGT_ROM: next_rdata = rom_rd;
                TGT_RAM: next_rdata = ram_rd;
                default: next_rdata = ALL_ONES;
            endcase
        end
    end

    // Single-cycle registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= ALL_ONES;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= next_rdata;
        end
    end

    AST_LOW_ROM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[23:21] == 3'b000) |-> !ram_cs); // R1
    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs)); // R2
    AST_WE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wr_unlock); // R3
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11

endmodule

// File: tb/cart_save_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_save_mapper_tb_top;

    localparam int RAM_AW = 10;
    localparam int NBYTE  = 1 << RAM_AW;
    localparam int NWORD  = NBYTE / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [23:0]       req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_word = 1'b0;
    logic [15:0]       req_wdata = '0;
    logic [1:0]        cfg_lane = 2'b00;
    logic [RAM_AW-1:0] cfg_mask = '1;
    logic [15:0]       rom_rdata;
    logic [15:0]       ram_rdata;
    logic              rom_cs;
    logic [20:0]       rom_addr;
    logic              ram_cs;
    logic              ram_we;
    logic [1:0]        ram_be;
    logic [RAM_AW-2:0] ram_addr;
    logic [15:0]       ram_wdata;
    logic              rsp_valid;
    logic [15:0]       rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cart_save_mapper #(.RAM_AW(RAM_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
        .cfg_lane(cfg_lane), .cfg_mask(cfg_mask), .rom_rdata(rom_rdata),
        .ram_rdata(ram_rdata), .rom_cs(rom_cs), .rom_addr(rom_addr),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Environment: ROM contents are a function of the word address.
    function automatic logic [15:0] rom_word(input logic [20:0] wa);
        return {wa[7:0] ^ 8'hC3, wa[15:8] ^ {3'b000, wa[20:16]}};
    endfunction
    assign rom_rdata = rom_word(rom_addr);

    // Environment: 16-bit RAM with byte enables.
    logic [15:0] mem [0:NWORD-1];
    assign ram_rdata = ram_cs ? mem[ram_addr] : 16'h0000;
    always @(posedge clk) begin
        if (ram_we) begin
            if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
            if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
        end
    end

    // Reference model state.
    logic [7:0] m_reg [0:7];
    logic [7:0] ref_b [0:NBYTE-1];
    logic [7:0] ref_h [0:NWORD-1];

    function automatic logic [15:0] dup(input logic [7:0] b);
        return {b, b};
    endfunction

    function automatic logic in_ram(input logic [23:0] a);
        return (a[23:21] == 3'b001) && m_reg[0][0];
    endfunction

    function automatic logic [15:0] exp_read(input logic [23:0] a, input logic word);
        logic [RAM_AW-1:0] o;
        logic [15:0] w;
        o = a[RAM_AW-1:0] & cfg_mask;
        if (word) o[0] = 1'b0;
        if (a[23:22] == 2'b00 && !in_ram(a)) begin
            w = rom_word(a[21:1]);
            return word ? w : dup(a[0] ? w[7:0] : w[15:8]);
        end
        if (!in_ram(a)) return 16'hFFFF;
        case (cfg_lane)
            2'b00: return word ? {ref_b[o], ref_b[o | 1]} : dup(ref_b[o]);
            2'b10: return word ? {ref_h[o >> 1], 8'hFF} : (o[0] ? 16'hFFFF : dup(ref_h[o >> 1]));
            2'b11: return word ? {8'hFF, ref_h[o >> 1]} : (o[0] ? dup(ref_h[o >> 1]) : 16'hFFFF);
            default: return 16'hFFFF;
        endcase
    endfunction

    task automatic model_write(input logic [23:0] a, input logic word, input logic [15:0] d);
        logic [RAM_AW-1:0] o;
        o = a[RAM_AW-1:0] & cfg_mask;
        if (word) o[0] = 1'b0;
        if (a[23:8] == 16'hA130) begin
            if (word || a[0]) m_reg[a[3:1]] = d[7:0];
        end else if (in_ram(a) && m_reg[0][1:0] == 2'b01) begin
            case (cfg_lane)
                2'b00: if (word) begin ref_b[o] = d[15:8]; ref_b[o | 1] = d[7:0]; end
                       else ref_b[o] = d[7:0];
                2'b10: if (word) ref_h[o >> 1] = d[15:8]; else if (!o[0]) ref_h[o >> 1] = d[7:0];
                2'b11: if (word) ref_h[o >> 1] = d[7:0];  else if (o[0])  ref_h[o >> 1] = d[7:0];
                default: ;
            endcase
        end
    endtask

    function automatic string tag_for(input logic [23:0] a);
        if (a[23:8] == 16'hA130) return "R4";
        if (a[23:21] == 3'b000) return "R1";
        if (a[23:22] != 2'b00) return "R11";
        if (!m_reg[0][0]) return "R2";
        case (cfg_lane)
            2'b00: return "R6";
            2'b10: return "R7";
            2'b11: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < NWORD; i++) begin mem[i] = '0; ref_h[i] = '0; end
        for (int i = 0; i < NBYTE; i++) ref_b[i] = '0;
    endtask

    // One request: drive on a falling edge, sample on the next one.
    task automatic access(input logic [23:0] a, input logic wr, input logic word,
                          input logic [15:0] d, input string tag);
        logic [15:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_word = word; req_wdata = d;
        exp = wr ? 16'hFFFF : exp_read(a, word);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, "R11", {31'd0, rsp_valid}, 32'd1);
        check(rsp_rdata === exp, tag, {16'd0, rsp_rdata}, {16'd0, exp});
        if (wr) model_write(a, word, d);
    endtask

    task automatic rd(input logic [23:0] a, input logic word);
        access(a, 1'b0, word, 16'h0000, tag_for(a));
    endtask

    task automatic wr(input logic [23:0] a, input logic word, input logic [15:0] d);
        access(a, 1'b1, word, d, "R11");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        clear_mem();
        repeat (4) @(negedge clk);
        check(rsp_valid === 1'b0, "R5", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R11", {31'd0, rsp_valid}, 32'd0);

        // R5: after reset the window shows ROM.
        access(24'h200010, 1'b0, 1'b1, 16'h0, "R5");
        rd(24'h000100, 1'b1);
        rd(24'h000101, 1'b0);
        rd(24'h1FFFFE, 1'b1);
        rd(24'h800000, 1'b1);
        rd(24'hA13001, 1'b1);

        // R4: even byte write and write to another index do not map RAM.
        wr(24'hA13000, 1'b0, 16'h0001);
        access(24'h200000, 1'b0, 1'b1, 16'h0, "R4");
        wr(24'hA13003, 1'b0, 16'h0001);
        access(24'h200000, 1'b0, 1'b1, 16'h0, "R4");

        // R3: mapped but locked (value 11): writes dropped.
        wr(24'hA13001, 1'b0, 16'h0003);
        wr(24'h200004, 1'b1, 16'h1234);
        wr(24'h200009, 1'b0, 16'h0077);
        access(24'h200004, 1'b0, 1'b1, 16'h0, "R3");
        access(24'h200008, 1'b0, 1'b1, 16'h0, "R3");

        // Unlock by word write; R6 both-lane behaviour.
        wr(24'hA13000, 1'b1, 16'hFF01);
        wr(24'h200004, 1'b1, 16'h1234);
        rd(24'h200004, 1'b1);
        wr(24'h200007, 1'b0, 16'h00AB);
        rd(24'h200007, 1'b0);
        rd(24'h200006, 1'b1);

        // R10: aliasing with a smaller mask.
        cfg_mask = 10'h0FF;
        wr(24'h200010, 1'b1, 16'hBEEF);
        access(24'h200110, 1'b0, 1'b1, 16'h0, "R10");
        access(24'h3FFF11, 1'b0, 1'b0, 16'h0, "R10");
        cfg_mask = '1;

        // R12: RAM port mapping, sampled in the request cycle.
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h200013; req_write = 1'b1; req_word = 1'b0; req_wdata = 16'h005A;
        #1;
        check(ram_cs === 1'b1 && ram_we === 1'b1, "R12", {30'd0, ram_cs, ram_we}, 32'd3);
        check(ram_be === 2'b01, "R12", {30'd0, ram_be}, 32'd1);
        check(ram_addr === 9'd9, "R12", {23'd0, ram_addr}, 32'd9);
        check(rom_cs === 1'b0, "R12", {31'd0, rom_cs}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        model_write(24'h200013, 1'b0, 16'h005A);
        rd(24'h200012, 1'b1);

        // R1: ROM select and address for a low read.
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h012346; req_write = 1'b0; req_word = 1'b1;
        #1;
        check(rom_cs === 1'b1 && ram_cs === 1'b0, "R1", {30'd0, rom_cs, ram_cs}, 32'd2);
        check(rom_addr === 21'h0091A3, "R1", {11'd0, rom_addr}, 32'h0091A3);
        @(negedge clk);
        req_valid = 1'b0;

        // Randomised phases, one per lane code.
        for (int ph = 0; ph < 4; ph++) begin
            cfg_lane = (ph == 0) ? 2'b00 : (ph == 1) ? 2'b10 : (ph == 2) ? 2'b11 : 2'b01;
            cfg_mask = (ph == 1) ? 10'h1FF : (ph == 3) ? 10'h0FF : 10'h3FF;
            clear_mem();
            wr(24'hA13000, 1'b1, 16'h0001);
            for (int n = 0; n < 500; n++) begin
                int k;
                logic [23:0] a;
                logic [15:0] d;
                k = $urandom_range(0, 99);
                d = 16'($urandom);
                if (k < 62) a = 24'h200000 | 24'($urandom_range(0, 4095));
                else if (k < 80) a = 24'($urandom_range(0, 24'h1FFFFF));
                else if (k < 92) a = 24'hA13000 | 24'($urandom_range(0, 15));
                else a = 24'h800000 | 24'($urandom_range(0, 255));
                if (k >= 80 && k < 92) begin
                    d = {8'h00, 6'd0, 2'($urandom_range(0, 3))};
                    if ($urandom_range(0, 3) != 0) d[1:0] = 2'b01;
                    wr(a, 1'($urandom), d);
                end else if ($urandom_range(0, 2) == 0) begin
                    wr(a, 1'($urandom), d);
                end else begin
                    rd(a, 1'($urandom));
                end
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule